// File: doc/BRIEF.md
# Slotted Dual-Bus Cell Arbiter

This block decides, slot by slot, which line card may place a cell on each of two shared slotted cell buses. A slot is as long as one 53-byte cell plus a 3-byte internal header (56 bytes). It is cut into bus cycles by a free-running slot timer. At every slot boundary the arbiter samples the cards' request lines, the destination of each card's head cell, the per-card congestion flags and the per-bus error flags. It then issues at most one grant per bus, and that grant is held unchanged for the whole following slot.

Every card can receive from both buses but transmits on only one. With both buses healthy, the lower half of the cards transmit on bus A and the upper half on bus B. If exactly one bus reports an error at a boundary, every card is moved onto the surviving bus for the next slot. A request whose head cell is addressed to a congested card is masked before arbitration. On each bus, a round-robin pointer starts its search just after the card it last granted.

Top module: `cbus_slot_arbiter`

## Requirements
- R1: `slot_start` is high in the first cycle of every slot, and a slot lasts ceil(SLOT_BYTES/BUS_BYTES) cycles (7 by default). Grants and `tx_on_b` change only at the start of a slot.
- R2: With `bus_err` = 2'b00, cards 0..N/2-1 have `tx_on_b` = 0 and can be granted only on `grant_a`. Cards N/2..N-1 have `tx_on_b` = 1 and can be granted only on `grant_b`.
- R3: With `bus_err` = 2'b01 (bit 0 = bus A failed), every card has `tx_on_b` = 1 and grants appear only on `grant_b`. With 2'b10 (bit 1 = bus B failed), every card has `tx_on_b` = 0 and grants appear only on `grant_a`.
- R4: With `bus_err` = 2'b11, no grant is issued on either bus and `tx_on_b` returns to the split of R2.
- R5: `bus_err` is sampled only at a slot boundary. A change in the middle of a slot alters neither `tx_on_b` nor the grants before the next slot starts.
- R6: Each bus grant is one-hot or zero, goes only to a card that requested at the boundary, and no card is granted on both buses.
- R7: Card i's destination is `dest[i*DW +: DW]`. A request whose destination card has its `bp` bit set at the boundary is not granted.
- R8: On each bus the search starts at the card after the one last granted (wrapping from N-1 to 0). The first eligible card found wins.
- R9: If a bus has no eligible card, that bus is idle for the slot and its round-robin pointer does not move.
- R10: When all cards of a bus request continuously and nothing is blocked, each of them is granted exactly once in any window of as many slots as that bus has cards.
- R11: During and right after reset, all grants are zero and `tx_on_b` shows the split of R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | N_CARDS | Card i holds a cell to send |
| dest | input | N_CARDS*DW | Destination card index of each head cell |
| bp | input | N_CARDS | Card i is congested and accepts no cells |
| bus_err | input | 2 | Bit 0: bus A failed, bit 1: bus B failed |
| grant_a | output | N_CARDS | One-hot grant for bus A, held for a slot |
| grant_b | output | N_CARDS | One-hot grant for bus B, held for a slot |
| tx_on_b | output | N_CARDS | Transmit bus of card i (0 = A, 1 = B) |
| slot_start | output | 1 | First cycle of a slot |

## Verification
The bench drives the pointer across the wrap from card 7 to card 0, asks for an idle slot with nobody requesting, and checks that the next winner shows the pointer stayed where it was. A design that advanced the pointer on an empty slot, or restarted the search from zero, would pick the wrong card. It blocks one card by congesting its destination and then congests the common destination of all cards. A design that masked on the requester's own flag, or left masking out, would grant a stalled cell. It fails each bus in turn, then both, and flips `bus_err` in mid-slot. A design that sampled the flag combinationally would move cards off their bus partway through a slot.

// File: rtl/cbus_pkg.sv
package cbus_pkg;

    // Transmit routing for one slot, derived from the two bus error flags.
    typedef enum logic [1:0] {
        ROUTE_SPLIT = 2'd0,
        ROUTE_ALL_A = 2'd1,
        ROUTE_ALL_B = 2'd2,
        ROUTE_NONE  = 2'd3
    } route_e;

    localparam int ERR_BIT_A = 0;
    localparam int ERR_BIT_B = 1;

    function automatic route_e route_of(input logic [1:0] err);
        route_e r;
        case ({err[ERR_BIT_B], err[ERR_BIT_A]})
            2'b00:   r = ROUTE_SPLIT;
            2'b01:   r = ROUTE_ALL_B;
            2'b10:   r = ROUTE_ALL_A;
            default: r = ROUTE_NONE;
        endcase
        return r;
    endfunction

    // 1 when a card transmits on bus B under routing r.
    function automatic logic on_bus_b(input route_e r, input logic upper_half);
        logic b;
        case (r)
            ROUTE_ALL_A: b = 1'b0;
            ROUTE_ALL_B: b = 1'b1;
            default:     b = upper_half;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/cbus_slot_timer.sv
module cbus_slot_timer #(
    parameter int SLOT_CYC = 7
) (
    input  logic clk,
    input  logic rst,
    output logic slot_start,
    output logic slot_end
);
    localparam int CW = (SLOT_CYC > 1) ? $clog2(SLOT_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(SLOT_CYC - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (cnt == LAST)
            cnt <= '0;
        else
            cnt <= cnt + CW'(1);
    end

    assign slot_start = (cnt == '0);
    assign slot_end   = (cnt == LAST);

    // R1
    next_slot_chk: assert property (@(posedge clk) disable iff (rst)
        slot_end |=> slot_start);

    // R1
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);

endmodule

// File: rtl/cbus_dest_mask.sv
module cbus_dest_mask #(
    parameter int N  = 8,
    parameter int DW = 3
) (
    input  logic [N-1:0]    req,
    input  logic [N*DW-1:0] dest,
    input  logic [N-1:0]    bp,
    output logic [N-1:0]    elig
);
    for (genvar i = 0; i < N; i++) begin : g_card
        logic [DW-1:0] d;
        logic          blocked;
        assign d = dest[i*DW +: DW];
        always_comb begin
            blocked = 1'b1;
            for (int k = 0; k < N; k++) begin
                if (int'(d) == k) blocked = bp[k];
            end
        end
        assign elig[i] = req[i] & ~blocked;
    end

endmodule

// File: rtl/cbus_rr_lane.sv
module cbus_rr_lane #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         advance,
    input  logic [N-1:0] cand,
    output logic [N-1:0] grant
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;
    localparam logic [IW-1:0] TOP = IW'(N - 1);

    logic [IW-1:0] ptr;
    logic [IW-1:0] win;
    logic [IW-1:0] ptr_next;
    logic          found;
    int            scan;

    always_comb begin
        found = 1'b0;
        win   = '0;
        scan  = 0;
        for (int k = 0; k < N; k++) begin
            scan = int'(ptr) + k;
            if (scan >= N) scan = scan - N;
            if (!found && cand[scan]) begin
                found = 1'b1;
                win   = IW'(scan);
            end
        end
    end

    assign ptr_next = (win == TOP) ? '0 : win + IW'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            grant <= '0;
            ptr   <= '0;
        end else if (advance) begin
            grant <= found ? (N'(1) << win) : '0;
            if (found) ptr <= ptr_next;
        end
    end

    // R6
    lane_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    // R1
    lane_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !advance |=> $stable(grant));

    // R6
    lane_cand_chk: assert property (@(posedge clk) disable iff (rst)
        advance |=> ((grant & ~$past(cand)) == '0));

    // R8
    lane_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (advance && (cand != '0)) |=> (grant != '0));

    // R9
    lane_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (advance && (cand == '0)) |=> (grant == '0) && $stable(ptr));

endmodule

// File: rtl/cbus_slot_arbiter.sv
module cbus_slot_arbiter
    import cbus_pkg::*;
#(
    parameter int N_CARDS    = 8,
    parameter int SLOT_BYTES = 56,
    parameter int BUS_BYTES  = 8,
    parameter int DW         = (N_CARDS > 1) ? $clog2(N_CARDS) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N_CARDS-1:0]   req,
    input  logic [N_CARDS*DW-1:0] dest,
    input  logic [N_CARDS-1:0]   bp,
    input  logic [1:0]           bus_err,
    output logic [N_CARDS-1:0]   grant_a,
    output logic [N_CARDS-1:0]   grant_b,
    output logic [N_CARDS-1:0]   tx_on_b,
    output logic                 slot_start
);
    localparam int SLOT_CYC = (SLOT_BYTES + BUS_BYTES - 1) / BUS_BYTES;
    localparam int HALF     = N_CARDS / 2;

    logic               slot_end;
    logic [N_CARDS-1:0] elig;
    logic [N_CARDS-1:0] sel_now;
    logic [N_CARDS-1:0] cand_a;
    logic [N_CARDS-1:0] cand_b;
    logic               bus_live;
    route_e             route_now;
    route_e             route_q;

    cbus_slot_timer #(.SLOT_CYC(SLOT_CYC)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .slot_start (slot_start),
        .slot_end   (slot_end)
    );

    cbus_dest_mask #(.N(N_CARDS), .DW(DW)) u_mask (
        .req  (req),
        .dest (dest),
        .bp   (bp),
        .elig (elig)
    );

    assign route_now = route_of(bus_err);
    assign bus_live  = (route_now != ROUTE_NONE);

    for (genvar i = 0; i < N_CARDS; i++) begin : g_route
        assign sel_now[i] = on_bus_b(route_now, i >= HALF);
        assign tx_on_b[i] = on_bus_b(route_q, i >= HALF);
    end

    assign cand_a = elig & ~sel_now & {N_CARDS{bus_live}};
    assign cand_b = elig &  sel_now & {N_CARDS{bus_live}};

    always_ff @(posedge clk) begin
        if (rst)
            route_q <= ROUTE_SPLIT;
        else if (slot_end)
            route_q <= route_now;
    end

    cbus_rr_lane #(.N(N_CARDS)) u_lane_a (
        .clk     (clk),
        .rst     (rst),
        .advance (slot_end),
        .cand    (cand_a),
        .grant   (grant_a)
    );

    cbus_rr_lane #(.N(N_CARDS)) u_lane_b (
        .clk     (clk),
        .rst     (rst),
        .advance (slot_end),
        .cand    (cand_b),
        .grant   (grant_b)
    );

    // R6
    no_dual_grant_chk: assert property (@(posedge clk) disable iff (rst)
        (grant_a & grant_b) == '0);

    // R3
    grant_a_bus_chk: assert property (@(posedge clk) disable iff (rst)
        (grant_a & tx_on_b) == '0);

    // R3
    grant_b_bus_chk: assert property (@(posedge clk) disable iff (rst)
        (grant_b & ~tx_on_b) == '0);

    // R5
    route_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !slot_end |=> $stable(tx_on_b));

    // R4
    both_down_chk: assert property (@(posedge clk) disable iff (rst)
        (slot_end && bus_err == 2'b11) |=> (grant_a == '0) && (grant_b == '0));

endmodule

// File: tb/tb_cbus_slot_arbiter.sv
`timescale 1ns/1ps
module tb_cbus_slot_arbiter;

    localparam int N  = 8;
    localparam int DW = 3;

    logic          clk = 1'b0;
    logic          rst;
    logic [N-1:0]  req;
    logic [N*DW-1:0] dest;
    logic [N-1:0]  bp;
    logic [1:0]    bus_err;
    logic [N-1:0]  grant_a;
    logic [N-1:0]  grant_b;
    logic [N-1:0]  tx_on_b;
    logic          slot_start;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    cbus_slot_arbiter #(.N_CARDS(N), .SLOT_BYTES(56), .BUS_BYTES(8)) dut (
        .clk        (clk),
        .rst        (rst),
        .req        (req),
        .dest       (dest),
        .bp         (bp),
        .bus_err    (bus_err),
        .grant_a    (grant_a),
        .grant_b    (grant_b),
        .tx_on_b    (tx_on_b),
        .slot_start (slot_start)
    );

    typedef struct packed {
        logic [7:0]  req;
        logic [7:0]  bp;
        logic [23:0] dest;
        logic [1:0]  err;
        logic [7:0]  exp_a;
        logic [7:0]  exp_b;
        logic [7:0]  exp_sel;
        logic [3:0]  rq;
    } vec_t;

    // Expected values follow the pointer rules: A and B pointers start at 0.
    localparam vec_t VECS [0:14] = '{
        '{8'hFF, 8'h00, 24'h0,     2'b00, 8'h01, 8'h10, 8'hF0, 4'd2},  // R2
        '{8'hFF, 8'h00, 24'h0,     2'b00, 8'h02, 8'h20, 8'hF0, 4'd8},  // R8
        '{8'h85, 8'h00, 24'h0,     2'b00, 8'h04, 8'h80, 8'hF0, 4'd8},  // R8 wrap on B
        '{8'h00, 8'h00, 24'h0,     2'b00, 8'h00, 8'h00, 8'hF0, 4'd9},  // R9 idle
        '{8'h09, 8'h00, 24'h0,     2'b00, 8'h08, 8'h00, 8'hF0, 4'd9},  // R9 ptr held
        '{8'h09, 8'h00, 24'h0,     2'b00, 8'h01, 8'h00, 8'hF0, 4'd8},  // R8 wrap on A
        '{8'h0F, 8'h20, 24'h28,    2'b00, 8'h04, 8'h00, 8'hF0, 4'd7},  // R7 card 1 blocked
        '{8'h02, 8'h20, 24'h28,    2'b00, 8'h00, 8'h00, 8'hF0, 4'd7},  // R7 only blocked one
        '{8'hFF, 8'h00, 24'h0,     2'b01, 8'h00, 8'h01, 8'hFF, 4'd3},  // R3 A failed
        '{8'hFF, 8'h00, 24'h0,     2'b01, 8'h00, 8'h02, 8'hFF, 4'd3},  // R3
        '{8'hFF, 8'h00, 24'h0,     2'b10, 8'h08, 8'h00, 8'h00, 4'd3},  // R3 B failed
        '{8'hFF, 8'h00, 24'h0,     2'b10, 8'h10, 8'h00, 8'h00, 4'd3},  // R3
        '{8'hFF, 8'h00, 24'h0,     2'b11, 8'h00, 8'h00, 8'hF0, 4'd4},  // R4
        '{8'hFF, 8'h00, 24'h0,     2'b00, 8'h01, 8'h10, 8'hF0, 4'd6},  // R6 recovery
        '{8'hFF, 8'h01, 24'h0,     2'b00, 8'h00, 8'h00, 8'hF0, 4'd7}   // R7 common dest
    };

    task automatic check8(input string rq, input string what,
                          input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    // Called at a negedge where slot_start is high; returns at the next one.
    task automatic run_slot(input logic [7:0] r, input logic [7:0] b,
                            input logic [23:0] d, input logic [1:0] e);
        req = r; bp = b; dest = d; bus_err = e;
        @(negedge clk);
        while (!slot_start) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL R1 watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; req = '0; bp = '0; dest = '0; bus_err = 2'b00;
        repeat (3) @(negedge clk);
        check8("R11", "reset grant_a", grant_a, 8'h00);
        check8("R11", "reset grant_b", grant_b, 8'h00);
        check8("R11", "reset tx_on_b", tx_on_b, 8'hF0);
        rst = 1'b0;
        @(negedge clk);
        while (!slot_start) @(negedge clk);
        check8("R11", "post-reset grant_a", grant_a, 8'h00);

        for (int v = 0; v < 15; v++) begin
            string tag;
            tag = $sformatf("R%0d", VECS[v].rq);
            run_slot(VECS[v].req, VECS[v].bp, VECS[v].dest, VECS[v].err);
            check8(tag, $sformatf("vec %0d grant_a", v), grant_a, VECS[v].exp_a);
            check8(tag, $sformatf("vec %0d grant_b", v), grant_b, VECS[v].exp_b);
            check8(tag, $sformatf("vec %0d tx_on_b", v), tx_on_b, VECS[v].exp_sel);
        end

        // R10: four slots, every card granted exactly once across both buses.
        begin
            logic [7:0] seen;
            logic [7:0] dup;
            seen = '0; dup = '0;
            for (int s = 0; s < 4; s++) begin
                run_slot(8'hFF, 8'h00, 24'h0, 2'b00);
                dup  = dup | (seen & (grant_a | grant_b));
                seen = seen | grant_a | grant_b;
            end
            check8("R10", "cards served", seen, 8'hFF);
            check8("R10", "cards served twice", dup, 8'h00);
        end

        // R5: bus_err flips mid-slot, takes effect only at the next slot.
        begin
            logic [7:0] ga0;
            logic [7:0] gb0;
            run_slot(8'hFF, 8'h00, 24'h0, 2'b00);
            ga0 = grant_a; gb0 = grant_b;
            repeat (2) @(negedge clk);
            bus_err = 2'b01;
            @(negedge clk);
            check8("R5", "mid-slot tx_on_b", tx_on_b, 8'hF0);
            check8("R5", "mid-slot grant_a", grant_a, ga0);
            check8("R5", "mid-slot grant_b", grant_b, gb0);
            while (!slot_start) @(negedge clk);
            check8("R5", "next-slot tx_on_b", tx_on_b, 8'hFF);
            check8("R5", "next-slot grant_a", grant_a, 8'h00);
        end

        // R1: slot length in cycles.
        begin
            int len;
            len = 0;
            @(negedge clk); len++;
            while (!slot_start) begin @(negedge clk); len++; end
            check8("R1", "slot length", 8'(len), 8'd7);
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule